// File: doc/BRIEF.md
# Isolatable Cache Data Store

This block holds the instruction and data cache arrays of a small 32-bit RISC core. It sits between the core's load/store unit and the external memory port. In normal operation every load and store passes through to the external port, and the read data from that port is returned to the core. When the isolate input is high, loads and stores never reach the external port. They address one of the two cache arrays directly, as plain RAM. The data array is the default target, and the swap input redirects the access to the instruction array.

Both arrays are built from 32-bit words, and each array's depth is its byte size divided by four. Byte and halfword accesses choose a lane inside the word by XOR-ing the low address bits with a constant that depends on the configured byte order. Before the range check, the upper three address bits are discarded. An isolated read past the end of the selected array returns all ones at the access width. An isolated write past the end changes nothing. Read results are registered and appear one cycle after the request.

Top module: `cds_cache_store`

## Requirements
- R1: After reset, rd_valid is 0 and rd_data is 0, and both external strobes are low while no request is driven.
- R2: With isolate low, a read raises ext_rd_en and a write raises ext_wr_en in the same cycle as the request, with ext_addr, ext_size and ext_wdata equal to the request. Read data sampled from ext_rdata appears on rd_data one cycle later.
- R3: With isolate high, ext_rd_en and ext_wr_en stay low for every request.
- R4: With isolate high and swap low, a word write at any byte address below DCACHE_BYTES, up to and including the last word, can be read back unchanged.
- R5: Address bits 31..29 are ignored, so an address with those bits set reaches the same array word.
- R6: An isolated read at or beyond the selected array's byte size returns 0x000000FF for a byte (size 2'b00), 0x0000FFFF for a halfword (size 2'b01), and 0xFFFFFFFF for a word (size 2'b10).
- R7: An isolated write at or beyond the selected array's byte size leaves every array word unchanged, including the word its low index bits would alias.
- R8: With BIG_ENDIAN=1 (the default), a byte at offset o lives in word bits [8*(3-o)+7 : 8*(3-o)]. A halfword at offset bit 1 = h lives in bits [16*(1-h)+15 : 16*(1-h)]. Byte and halfword reads return the value right-justified with zeros above it.
- R9: Byte and halfword writes change only their own lanes of the stored word.
- R10: With swap high, isolated accesses use the instruction array and its ICACHE_BYTES range. The two arrays hold separate contents.
- R11: rd_valid is high exactly in the cycle after a read request, and low after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access strobe from the load/store unit |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| isolate | input | 1 | Route accesses to a cache array instead of external memory |
| swap | input | 1 | Select the instruction array when isolated |
| ext_rdata | input | 32 | Read data from the external memory port |
| ext_rd_en | output | 1 | External read strobe |
| ext_wr_en | output | 1 | External write strobe |
| ext_addr | output | 32 | External address |
| ext_size | output | 2 | External access size |
| ext_wdata | output | 32 | External write data |
| rd_valid | output | 1 | Registered read-result valid |
| rd_data | output | 32 | Registered read result, right-justified |

## Verification
The external strobes, address, size and write data are combinational, so they are due in the request cycle itself. The bench drives each request on a falling edge and samples these outputs 1 ns later, before the next rising edge. Read data and rd_valid pass through one register, so they are due after the first rising edge following the request. The bench samples them 1 ns after that edge and then removes the request. An ignored out-of-range write is checked at the ports: the bench reads back the aliased word through the normal path and expects its earlier value.

// File: rtl/cds_pkg.sv
package cds_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic        vld;
        logic [31:0] data;
    } rd_state_t;

    localparam logic [31:0] ADDR_KEEP = 32'h1FFF_FFFF;

    // Fill value for reads past the end of an isolated array
    function automatic logic [31:0] fill_ones(acc_size_e s);
        case (s)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cds_lane_steer.sv
module cds_lane_steer #(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [1:0]  size,
    input  logic [1:0]  offset,
    input  logic [31:0] wdata,
    input  logic [31:0] rword,
    output logic [3:0]  be,
    output logic [31:0] wword,
    output logic [31:0] rdata
);
    import cds_pkg::*;

    logic [1:0] byte_xor;
    logic       half_xor;

    generate
        if (BIG_ENDIAN) begin : g_big
            assign byte_xor = 2'b11;
            assign half_xor = 1'b1;
        end else begin : g_little
            assign byte_xor = 2'b00;
            assign half_xor = 1'b0;
        end
    endgenerate

    logic [1:0] blane;
    logic       hlane;

    always_comb begin
        blane = offset ^ byte_xor;
        hlane = offset[1] ^ half_xor;
        case (acc_size_e'(size))
            SZ_BYTE: begin
                be    = 4'b0001 << blane;
                wword = {4{wdata[7:0]}};
                rdata = {24'h0, rword[{blane, 3'b000} +: 8]};
            end
            SZ_HALF: begin
                be    = hlane ? 4'b1100 : 4'b0011;
                wword = {2{wdata[15:0]}};
                rdata = {16'h0, rword[{hlane, 4'b0000} +: 16]};
            end
            default: begin
                be    = 4'b1111;
                wword = wdata;
                rdata = rword;
            end
        endcase
    end

    // Lane enables must match the access width (R8, R9)
    always_comb begin
        if (!$isunknown(size) && !$isunknown(offset)) begin
            assert_lane_count_R9: assert (
                (size == 2'b00 && $countones(be) == 1) ||
                (size == 2'b01 && $countones(be) == 2) ||
                (size[1] && be == 4'b1111));
        end
    end

endmodule

// File: rtl/cds_bank.sv
module cds_bank #(
    parameter int DEPTH = 128
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [3:0]               be,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata
);
    logic [31:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) mem_q[idx][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign rdata = mem_q[idx];

endmodule

// File: rtl/cds_cache_store.sv
module cds_cache_store #(
    parameter int ICACHE_BYTES = 2048,
    parameter int DCACHE_BYTES = 512,
    parameter bit BIG_ENDIAN   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic        isolate,
    input  logic        swap,
    input  logic [31:0] ext_rdata,
    output logic        ext_rd_en,
    output logic        ext_wr_en,
    output logic [31:0] ext_addr,
    output logic [1:0]  ext_size,
    output logic [31:0] ext_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data
);
    import cds_pkg::*;

    localparam int IDEPTH = ICACHE_BYTES / 4;
    localparam int DDEPTH = DCACHE_BYTES / 4;
    localparam int IAW    = $clog2(IDEPTH);
    localparam int DAW    = $clog2(DDEPTH);

    logic [31:0] addr_m;
    logic [31:0] sel_bytes;
    logic        in_range;
    logic        iso_wr;
    logic        i_we, d_we;
    logic [31:0] i_rword, d_rword, sel_word;
    logic [3:0]  lane_be;
    logic [31:0] lane_wword, lane_rdata;
    rd_state_t   rd_d, rd_q;

    always_comb begin
        addr_m    = req_addr & ADDR_KEEP;
        sel_bytes = swap ? 32'(ICACHE_BYTES) : 32'(DCACHE_BYTES);
        in_range  = addr_m < sel_bytes;
        iso_wr    = req_valid && isolate && req_write && in_range;
        i_we      = iso_wr && swap;
        d_we      = iso_wr && !swap;
        sel_word  = swap ? i_rword : d_rword;
    end

    cds_lane_steer #(.BIG_ENDIAN(BIG_ENDIAN)) u_lane (
        .size   (req_size),
        .offset (addr_m[1:0]),
        .wdata  (req_wdata),
        .rword  (sel_word),
        .be     (lane_be),
        .wword  (lane_wword),
        .rdata  (lane_rdata)
    );

    cds_bank #(.DEPTH(IDEPTH)) u_ibank (
        .clk   (clk),
        .we    (i_we),
        .be    (lane_be),
        .idx   (addr_m[IAW+1:2]),
        .wdata (lane_wword),
        .rdata (i_rword)
    );

    cds_bank #(.DEPTH(DDEPTH)) u_dbank (
        .clk   (clk),
        .we    (d_we),
        .be    (lane_be),
        .idx   (addr_m[DAW+1:2]),
        .wdata (lane_wword),
        .rdata (d_rword)
    );

    // External port: cut off while isolated
    always_comb begin
        ext_rd_en = req_valid && !req_write && !isolate;
        ext_wr_en = req_valid && req_write && !isolate;
        ext_addr  = req_addr;
        ext_size  = req_size;
        ext_wdata = req_wdata;
    end

    // Next read result
    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = req_valid && !req_write;
        if (rd_d.vld) begin
            if (!isolate)      rd_d.data = ext_rdata;
            else if (in_range) rd_d.data = lane_rdata;
            else               rd_d.data = fill_ones(acc_size_e'(req_size));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid = rd_q.vld;
    assign rd_data  = rd_q.data;

    assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    assert_rvalid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    assert_oob_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && isolate && !in_range && req_size == 2'b00)
        |=> rd_data == 32'h0000_00FF);

    assert_oob_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && isolate && !in_range && req_size == 2'b01)
        |=> rd_data == 32'h0000_FFFF);

    assert_oob_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && isolate && !in_range && req_size == 2'b10)
        |=> rd_data == 32'hFFFF_FFFF);

endmodule

// File: tb/cds_cache_store_bench.sv
module cds_cache_store_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        isolate = 1'b0;
    logic        swap = 1'b0;
    logic [31:0] ext_rdata = '0;
    logic        ext_rd_en, ext_wr_en;
    logic [31:0] ext_addr, ext_wdata;
    logic [1:0]  ext_size;
    logic        rd_valid;
    logic [31:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cds_cache_store u_cds_cache_store (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .isolate(isolate), .swap(swap), .ext_rdata(ext_rdata),
        .ext_rd_en(ext_rd_en), .ext_wr_en(ext_wr_en), .ext_addr(ext_addr),
        .ext_size(ext_size), .ext_wdata(ext_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    typedef struct packed {
        logic        wr;
        logic        swp;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    // All vectors run isolated; data array 512 bytes, instruction array 2048 bytes
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 2'd2, 32'h0000_0000, 32'h1122_3344, 32'h0,          4'd4},  // R4
        '{1'b0, 1'b0, 2'd2, 32'h0000_0000, 32'h0,         32'h1122_3344,  4'd4},  // R4
        '{1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0,         32'h0000_0011,  4'd8},  // R8
        '{1'b0, 1'b0, 2'd0, 32'h0000_0003, 32'h0,         32'h0000_0044,  4'd8},  // R8
        '{1'b0, 1'b0, 2'd1, 32'h0000_0000, 32'h0,         32'h0000_1122,  4'd8},  // R8
        '{1'b0, 1'b0, 2'd1, 32'h0000_0002, 32'h0,         32'h0000_3344,  4'd8},  // R8
        '{1'b1, 1'b0, 2'd0, 32'h0000_0001, 32'h0000_00AA, 32'h0,          4'd9},  // R9
        '{1'b0, 1'b0, 2'd2, 32'h0000_0000, 32'h0,         32'h11AA_3344,  4'd9},  // R9
        '{1'b1, 1'b0, 2'd1, 32'h0000_0002, 32'h0000_BEEF, 32'h0,          4'd9},  // R9
        '{1'b0, 1'b0, 2'd2, 32'h0000_0000, 32'h0,         32'h11AA_BEEF,  4'd9},  // R9
        '{1'b0, 1'b0, 2'd2, 32'hE000_0000, 32'h0,         32'h11AA_BEEF,  4'd5},  // R5
        '{1'b0, 1'b0, 2'd0, 32'h0000_0200, 32'h0,         32'h0000_00FF,  4'd6},  // R6
        '{1'b0, 1'b0, 2'd1, 32'h0000_0202, 32'h0,         32'h0000_FFFF,  4'd6},  // R6
        '{1'b0, 1'b0, 2'd2, 32'h0000_07FC, 32'h0,         32'hFFFF_FFFF,  4'd6},  // R6
        '{1'b1, 1'b0, 2'd2, 32'h0000_0200, 32'hDEAD_BEEF, 32'h0,          4'd7},  // R7
        '{1'b0, 1'b0, 2'd2, 32'h0000_0000, 32'h0,         32'h11AA_BEEF,  4'd7},  // R7
        '{1'b1, 1'b0, 2'd2, 32'h0000_01FC, 32'h0BAD_CAFE, 32'h0,          4'd4},  // R4
        '{1'b0, 1'b0, 2'd2, 32'h0000_01FC, 32'h0,         32'h0BAD_CAFE,  4'd4},  // R4
        '{1'b1, 1'b1, 2'd2, 32'h0000_0400, 32'hCAFE_F00D, 32'h0,          4'd10}, // R10
        '{1'b0, 1'b1, 2'd2, 32'h0000_0400, 32'h0,         32'hCAFE_F00D,  4'd10}, // R10
        '{1'b1, 1'b1, 2'd2, 32'h0000_0000, 32'h5566_7788, 32'h0,          4'd10}, // R10
        '{1'b0, 1'b0, 2'd2, 32'h0000_0000, 32'h0,         32'h11AA_BEEF,  4'd10}, // R10
        '{1'b0, 1'b1, 2'd2, 32'h0000_0000, 32'h0,         32'h5566_7788,  4'd10}, // R10
        '{1'b0, 1'b1, 2'd2, 32'h0000_0800, 32'h0,         32'hFFFF_FFFF,  4'd10}, // R10
        '{1'b0, 1'b1, 2'd0, 32'h0000_0401, 32'h0,         32'h0000_00FE,  4'd8}   // R8
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 ext strobes", {30'b0, ext_rd_en, ext_wr_en}, 32'h0);

        // Table walk, isolated
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            isolate   = 1'b1;
            ext_rdata = 32'h5A5A_5A5A;
            req_write = VEC[i].wr;
            swap      = VEC[i].swp;
            req_size  = VEC[i].sz;
            req_addr  = VEC[i].addr;
            req_wdata = VEC[i].wd;
            #1;
            chk("R3 ext strobes low while isolated", {30'b0, ext_rd_en, ext_wr_en}, 32'h0);
            @(posedge clk);
            #1;
            chk("R11 rd_valid", {31'b0, rd_valid}, {31'b0, ~VEC[i].wr});
            if (!VEC[i].wr)
                chk($sformatf("R%0d read vector %0d", VEC[i].req, i), rd_data, VEC[i].exp);
            req_valid = 1'b0;
        end

        // Idle cycle: rd_valid drops (R11)
        @(posedge clk);
        #1 chk("R11 idle", {31'b0, rd_valid}, 32'h0);

        // Pass-through read (R2)
        @(negedge clk);
        isolate = 1'b0; swap = 1'b0; req_valid = 1'b1; req_write = 1'b0;
        req_size = 2'b10; req_addr = 32'h8000_0010; ext_rdata = 32'h1357_2468;
        #1;
        chk("R2 ext_rd_en", {31'b0, ext_rd_en}, 32'h1);
        chk("R2 ext_wr_en", {31'b0, ext_wr_en}, 32'h0);
        chk("R2 ext_addr", ext_addr, 32'h8000_0010);
        @(posedge clk);
        #1;
        chk("R2 rd_data from ext", rd_data, 32'h1357_2468);
        req_valid = 1'b0;

        // Pass-through write (R2)
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'b01;
        req_addr = 32'h0000_0000; req_wdata = 32'h2468_ACE0;
        #1;
        chk("R2 ext_wr_en", {31'b0, ext_wr_en}, 32'h1);
        chk("R2 ext_rd_en", {31'b0, ext_rd_en}, 32'h0);
        chk("R2 ext_wdata", ext_wdata, 32'h2468_ACE0);
        chk("R2 ext_size", {30'b0, ext_size}, 32'h1);
        @(posedge clk);
        #1;
        chk("R11 write gives no rd_valid", {31'b0, rd_valid}, 32'h0);
        req_valid = 1'b0;

        // The pass-through write must not have touched the data array (R3)
        @(negedge clk);
        isolate = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_size = 2'b10;
        req_addr = 32'h0000_0000;
        @(posedge clk);
        #1;
        chk("R3 array untouched by external write", rd_data, 32'h11AA_BEEF);
        req_valid = 1'b0;

        repeat (2) @(posedge clk);
        summary();
    end

endmodule